// File: doc/BRIEF.md
# Banked Stack Pointer Selector

This block keeps the stack pointers of a processor core that has two security states. It holds one main and one process pointer for each state, a stack-select bit for each state, and two lower-bound registers that guard the secure-state pointers. From the current security state and the execution mode (Thread or Handler), it works out which pointer is in use and drives that pointer on `active_sp` every cycle.

The rest of the core asks for stack adjustments through a request port: a push or pop of a given number of 32-bit words. One cycle later the block answers with the resulting pointer and a fault flag, and updates the pointer it used. A push by a secure pointer that would move below its limit, or below address zero, is refused. The pointer then stays as it was and the fault flag is raised. Software reaches every register through a bank-addressed read/write port, whatever the current mode is.

Top module: `banked_sp_unit`

## Requirements
- R1: The register port selects with a 3-bit code: 0 non-secure main, 1 non-secure process, 2 secure main, 3 secure process, 4 secure main limit, 5 secure process limit, 6 non-secure control, 7 secure control. A write takes effect at the clock edge where `reg_wr_en` is high. `reg_rd_data` shows the register selected by `reg_rd_sel` one cycle after the select is presented.
- R2: In Thread mode (`handler_mode`=0), the stack-select bit of the current security state picks the process pointer when it is 1 and the main pointer when it is 0. In Handler mode, the main pointer of the current state is always active.
- R3: Bits [1:0] of every pointer and limit register read as zero, and writes to those bits are dropped.
- R4: A request of N words with `req_valid` high produces `rsp_valid` high one cycle later. A pop returns and stores the active pointer plus 4N. A push that is not refused returns and stores the active pointer minus 4N.
- R5: In the secure state, a push whose resulting lowest address is below the active pointer's limit, or would fall below zero, is refused. `rsp_fault` is 1, `rsp_sp` equals the unchanged pointer, and the stored pointer does not change. A result exactly equal to the limit is allowed.
- R6: In the non-secure state, pushes never fault, and the pointer wraps modulo 2^32.
- R7: Pops never fault, even when the pointer is below its limit.
- R8: Synchronous reset clears all pointers, limits and stack-select bits, so `active_sp` and every register read return 0.
- R9: A control register keeps only its stack-select bit, at bit position 1. A read returns that bit at position 1 and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_state | input | 1 | Current security state, 1 = secure |
| handler_mode | input | 1 | 1 = Handler mode, 0 = Thread mode |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register write select code |
| reg_wr_data | input | DW | Register write data |
| reg_rd_sel | input | 3 | Register read select code |
| reg_rd_data | output | DW | Registered read data |
| req_valid | input | 1 | Stack adjustment request |
| req_push | input | 1 | 1 = push, 0 = pop |
| req_words | input | CNT_W | Number of words to move |
| active_sp | output | DW | Pointer currently selected |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_sp | output | DW | Pointer after the request |
| rsp_fault | output | 1 | Push refused by the limit check |

## Verification
The hardest case to reach is a refused secure push where the lower bound is crossed only by wrap-around below address zero, rather than by landing under the limit register. The stimulus loads a secure main pointer of 4 and a limit of 0 through the register port, then pushes two words in Handler mode. Another hard case is the exact-boundary push that lands on the limit: a table walk steps the secure main pointer down until it reaches the limit value, then pushes once more.

// File: rtl/stkp_pkg.sv
package stkp_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_MAIN_NS  = 3'd0,
    SEL_PROC_NS  = 3'd1,
    SEL_MAIN_S   = 3'd2,
    SEL_PROC_S   = 3'd3,
    SEL_LIM_MAIN = 3'd4,
    SEL_LIM_PROC = 3'd5,
    SEL_CTRL_NS  = 3'd6,
    SEL_CTRL_S   = 3'd7
  } reg_sel_e;

  // Position of the stack-select bit inside a control word
  localparam int SPSEL_BIT = 1;
endpackage

// File: rtl/stkp_bank_sel.sv
module stkp_bank_sel #(
  parameter int SEC_EXT = 1
) (
  input  logic       sec_in,
  input  logic       handler,
  input  logic [1:0] spsel,
  output logic       sec_eff,
  output logic [1:0] ptr_idx
);
  generate
    if (SEC_EXT != 0) begin : g_sec
      assign sec_eff = sec_in;
    end else begin : g_nosec
      assign sec_eff = 1'b0;
    end
  endgenerate

  // index = {secure, process}; Handler mode forces the main pointer
  assign ptr_idx = {sec_eff, ~handler & spsel[sec_eff]};
endmodule

// File: rtl/stkp_adjust.sv
module stkp_adjust #(
  parameter int DW         = 32,
  parameter int CNT_W      = 3,
  parameter int WORD_BYTES = 4
) (
  input  logic [DW-1:0]    cur_sp,
  input  logic             push,
  input  logic [CNT_W-1:0] words,
  input  logic [DW-1:0]    lim,
  input  logic             lim_en,
  output logic [DW-1:0]    nxt_sp,
  output logic             fault
);
  localparam int SHIFT = $clog2(WORD_BYTES);

  logic [DW:0]   step;
  logic [DW:0]   dec;
  logic [DW-1:0] inc;
  logic          borrow;

  assign step   = {{(DW+1-CNT_W){1'b0}}, words} << SHIFT;
  assign dec    = {1'b0, cur_sp} - step;
  assign inc    = cur_sp + step[DW-1:0];
  assign borrow = dec[DW];
  assign fault  = push & lim_en & (borrow | (dec[DW-1:0] < lim));

  always_comb begin
    if (!push)     nxt_sp = inc;
    else if (fault) nxt_sp = cur_sp;
    else           nxt_sp = dec[DW-1:0];
  end
endmodule

// File: rtl/stkp_regs.sv
module stkp_regs
  import stkp_pkg::*;
#(
  parameter int DW         = 32,
  parameter int SEC_EXT    = 1,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             upd_en,
  input  logic [1:0]       upd_idx,
  input  logic [DW-1:0]    upd_val,
  output logic [DW-1:0]    sp_o  [4],
  output logic [DW-1:0]    lim_o [2],
  output logic [1:0]       spsel_o
);
  localparam logic [DW-1:0] KEEP = ~DW'(WORD_BYTES - 1);

  // Bank 0 = non-secure, bank 1 = secure (present only with SEC_EXT)
  for (genvar b = 0; b < 2; b++) begin : g_bank
    if (b == 0 || SEC_EXT != 0) begin : g_real
      logic [DW-1:0] sp_r [2];
      logic          sel_r;
      for (genvar p = 0; p < 2; p++) begin : g_ptr
        // register write wins over a same-cycle stack update
        always_ff @(posedge clk) begin
          if (rst)
            sp_r[p] <= '0;
          else if (wr_en && wr_sel == SEL_W'(2*b + p))
            sp_r[p] <= wr_data & KEEP;
          else if (upd_en && upd_idx == 2'(2*b + p))
            sp_r[p] <= upd_val;
        end
        assign sp_o[2*b+p] = sp_r[p];
      end
      always_ff @(posedge clk) begin
        if (rst)
          sel_r <= 1'b0;
        else if (wr_en && wr_sel == SEL_W'(6 + b))
          sel_r <= wr_data[SPSEL_BIT];
      end
      assign spsel_o[b] = sel_r;
    end else begin : g_tie
      assign sp_o[2*b]   = '0;
      assign sp_o[2*b+1] = '0;
      assign spsel_o[b]  = 1'b0;
    end
  end

  if (SEC_EXT != 0) begin : g_lim
    for (genvar l = 0; l < 2; l++) begin : g_one
      logic [DW-1:0] lim_r;
      always_ff @(posedge clk) begin
        if (rst)
          lim_r <= '0;
        else if (wr_en && wr_sel == SEL_W'(4 + l))
          lim_r <= wr_data & KEEP;
      end
      assign lim_o[l] = lim_r;
    end
  end else begin : g_nolim
    assign lim_o[0] = '0;
    assign lim_o[1] = '0;
  end
endmodule

// File: rtl/banked_sp_unit.sv
module banked_sp_unit
  import stkp_pkg::*;
#(
  parameter int DW         = 32,
  parameter int SEC_EXT    = 1,
  parameter int CNT_W      = 3,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_state,
  input  logic             handler_mode,
  input  logic             reg_wr_en,
  input  logic [2:0]       reg_wr_sel,
  input  logic [DW-1:0]    reg_wr_data,
  input  logic [2:0]       reg_rd_sel,
  output logic [DW-1:0]    reg_rd_data,
  input  logic             req_valid,
  input  logic             req_push,
  input  logic [CNT_W-1:0] req_words,
  output logic [DW-1:0]    active_sp,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_sp,
  output logic             rsp_fault
);
  logic [DW-1:0] sp_q  [4];
  logic [DW-1:0] lim_q [2];
  logic [1:0]    spsel_q;
  logic          sec_eff;
  logic [1:0]    ptr_idx;
  logic [DW-1:0] nxt_sp;
  logic          push_fault;
  logic [DW-1:0] rd_next;

  stkp_bank_sel #(.SEC_EXT(SEC_EXT)) u_sel (
    .sec_in  (sec_state),
    .handler (handler_mode),
    .spsel   (spsel_q),
    .sec_eff (sec_eff),
    .ptr_idx (ptr_idx)
  );

  assign active_sp = sp_q[ptr_idx];

  stkp_adjust #(.DW(DW), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_adj (
    .cur_sp (active_sp),
    .push   (req_push),
    .words  (req_words),
    .lim    (lim_q[ptr_idx[0]]),
    .lim_en (sec_eff),
    .nxt_sp (nxt_sp),
    .fault  (push_fault)
  );

  stkp_regs #(.DW(DW), .SEC_EXT(SEC_EXT), .WORD_BYTES(WORD_BYTES)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_sel  (reg_wr_sel),
    .wr_data (reg_wr_data),
    .upd_en  (req_valid),
    .upd_idx (ptr_idx),
    .upd_val (nxt_sp),
    .sp_o    (sp_q),
    .lim_o   (lim_q),
    .spsel_o (spsel_q)
  );

  always_comb begin
    rd_next = '0;
    case (reg_rd_sel)
      SEL_MAIN_NS, SEL_PROC_NS, SEL_MAIN_S, SEL_PROC_S: rd_next = sp_q[reg_rd_sel[1:0]];
      SEL_LIM_MAIN, SEL_LIM_PROC:                       rd_next = lim_q[reg_rd_sel[0]];
      default: rd_next[SPSEL_BIT] = spsel_q[reg_rd_sel[0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_data <= '0;
      rsp_valid   <= 1'b0;
      rsp_sp      <= '0;
      rsp_fault   <= 1'b0;
    end else begin
      reg_rd_data <= rd_next;
      rsp_valid   <= req_valid;
      if (req_valid) begin
        rsp_sp    <= nxt_sp;
        rsp_fault <= push_fault;
      end
    end
  end

  // R2: Handler mode never selects a process pointer
  a_r2_handler_main: assert property (@(posedge clk) disable iff (rst)
    handler_mode |-> !ptr_idx[0]);

  // R3: pointers stay word aligned
  a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
    (active_sp[1:0] == 2'b00) && (rsp_sp[1:0] == 2'b00));

  // R4: response strobe follows the request by one cycle
  a_r4_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r4_rsp_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R4: pop result is the old pointer plus the word step
  a_r4_pop_step: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_push) |=>
      rsp_sp == $past(active_sp) + DW'($past(req_words)) * DW'(WORD_BYTES));

  // R5: a refused push reports the unchanged pointer
  a_r5_fault_holds: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_push) |=> (!rsp_fault || rsp_sp == $past(active_sp)));

  // R6: non-secure requests never fault
  a_r6_ns_nofault: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !sec_state) |=> !rsp_fault);

  // R7: pops never fault
  a_r7_pop_nofault: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_push) |=> !rsp_fault);
endmodule

// File: tb/banked_sp_unit_test.sv
module banked_sp_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_state = 1'b1;
  logic        handler_mode = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_sel = '0;
  logic [31:0] reg_wr_data = '0;
  logic [2:0]  reg_rd_sel = '0;
  logic [31:0] reg_rd_data;
  logic        req_valid = 1'b0;
  logic        req_push = 1'b0;
  logic [2:0]  req_words = '0;
  logic [31:0] active_sp;
  logic        rsp_valid;
  logic [31:0] rsp_sp;
  logic        rsp_fault;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_sp_unit uut (
    .clk(clk), .rst(rst), .sec_state(sec_state), .handler_mode(handler_mode),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .req_valid(req_valid), .req_push(req_push), .req_words(req_words),
    .active_sp(active_sp), .rsp_valid(rsp_valid), .rsp_sp(rsp_sp),
    .rsp_fault(rsp_fault)
  );

  // {sec, handler, push, words[2:0], fault, sp[31:0]}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 32'h0000_0FF8},
    {1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 32'h0000_0FF0},
    {1'b1, 1'b0, 1'b1, 3'd1, 1'b1, 32'h0000_0FF0},
    {1'b1, 1'b0, 1'b0, 3'd3, 1'b0, 32'h0000_0FFC},
    {1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 32'h0000_0FF8},
    {1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 32'hFFFF_FFFC},
    {1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 32'h0000_0000},
    {1'b0, 1'b1, 1'b1, 3'd4, 1'b0, 32'h0000_2FF0},
    {1'b0, 1'b1, 1'b0, 3'd7, 1'b0, 32'h0000_300C},
    {1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 32'h0000_0FF8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = s; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_rd_sel = s;
    @(negedge clk);
    d = reg_rd_data;
  endtask

  task automatic req(input logic s, input logic h, input logic p, input logic [2:0] n);
    @(negedge clk);
    sec_state = s; handler_mode = h; req_valid = 1'b1; req_push = p; req_words = n;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R8: reset state
    chk("R8 active_sp", active_sp, 32'h0);
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), d);
      chk("R8 reg after reset", d, 32'h0);
    end

    // R1: setup through register port
    wr(3'd2, 32'h0000_1000);
    wr(3'd3, 32'h0000_2000);
    wr(3'd4, 32'h0000_0FF0);
    wr(3'd5, 32'h0000_1000);
    wr(3'd0, 32'h0000_3000);
    wr(3'd1, 32'h0000_0008);
    wr(3'd6, 32'h0000_0002);
    wr(3'd7, 32'h0000_0000);
    rd(3'd3, d); chk("R1 read secure process", d, 32'h0000_2000);
    rd(3'd4, d); chk("R1 read secure main limit", d, 32'h0000_0FF0);

    // R2/R4/R5/R6/R7 table walk
    for (int i = 0; i < NVEC; i++) begin
      req(VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35:33]);
      chk("R4 rsp_valid", {31'b0, rsp_valid}, 32'h1);
      chk("R4/R5/R6 rsp_sp", rsp_sp, VEC[i][31:0]);
      chk("R5/R6/R7 rsp_fault", {31'b0, rsp_fault}, {31'b0, VEC[i][32]});
      chk("R2 active_sp after request", active_sp, VEC[i][31:0]);
    end
    @(negedge clk);
    chk("R4 rsp_valid idle", {31'b0, rsp_valid}, 32'h0);

    // R9: control register keeps only bit 1
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, d); chk("R9 secure control", d, 32'h0000_0002);
    rd(3'd6, d); chk("R9 non-secure control", d, 32'h0000_0002);

    // R2: secure Thread with select bit picks the process pointer
    sec_state = 1'b1; handler_mode = 1'b0;
    @(negedge clk); chk("R2 secure thread process", active_sp, 32'h0000_2000);
    handler_mode = 1'b1;
    @(negedge clk); chk("R2 handler forces main", active_sp, 32'h0000_0FF8);
    req(1'b1, 1'b0, 1'b1, 3'd7);
    chk("R4 push seven words", rsp_sp, 32'h0000_1FE4);

    // R3: low bits dropped
    wr(3'd3, 32'h0000_1006);
    rd(3'd3, d); chk("R3 pointer low bits", d, 32'h0000_1004);
    wr(3'd0, 32'h0000_1237);
    rd(3'd0, d); chk("R3 pointer low bits ns", d, 32'h0000_1234);
    wr(3'd4, 32'h0000_0FF3);
    rd(3'd4, d); chk("R3 limit low bits", d, 32'h0000_0FF0);

    // R5: crossing the process limit
    req(1'b1, 1'b0, 1'b1, 3'd2);
    chk("R5 limit fault", {31'b0, rsp_fault}, 32'h1);
    chk("R5 pointer held", rsp_sp, 32'h0000_1004);
    rd(3'd3, d); chk("R5 stored pointer held", d, 32'h0000_1004);

    // R5: borrow below zero
    wr(3'd2, 32'h0000_0004);
    wr(3'd4, 32'h0000_0000);
    req(1'b1, 1'b1, 1'b1, 3'd2);
    chk("R5 wrap fault", {31'b0, rsp_fault}, 32'h1);
    chk("R5 wrap pointer held", rsp_sp, 32'h0000_0004);

    // R7: pop below limit does not fault
    wr(3'd4, 32'h0000_0100);
    req(1'b1, 1'b1, 1'b0, 3'd1);
    chk("R7 pop no fault", {31'b0, rsp_fault}, 32'h0);
    chk("R7 pop pointer", rsp_sp, 32'h0000_0008);

    // R8: reset again clears state
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    rd(3'd2, d); chk("R8 secure main after reset", d, 32'h0);
    rd(3'd7, d); chk("R8 control after reset", d, 32'h0);

    finish_run();
  end
endmodule